// File: doc/BRIEF.md
# Indexed Effective Address Unit

This unit turns a 10-bit addressing postbyte into a 20-bit effective address. The postbyte names a base register, an offset source and an auto-update action, and says whether the address is final or is a pointer to be fetched from memory. The caller supplies the current register contents and any immediate operands with the request. The unit returns the address together with the register write-backs that the auto-update needs. When indirection is requested, it first reads the pointer through its own memory read port.

A two-bit mode input selects plain addressing or fractional addressing. In fractional mode a full index-register offset contributes only its upper 10 bits. The two remaining mode codes stand for addressing schemes that this unit does not implement. They complete the request at once with an illegal-mode flag and no side effects. Requests that resolve directly may be issued on every cycle. An indirect request holds the unit busy until the memory answers.

Top module: `ea_unit`

## Requirements
- R1: Postbyte bits [2:0] pick the base: 0..3 = index registers W, X, Y, Z (`idx_vals` slices 0..3, W in the lowest 20 bits), 4 = `sp_s`, 5 = `sp_u`, 6 = `pc_val`, 7 = no base (value 0).
- R2: Postbyte bits [6:3] pick the offset: 0..3 = accumulators A..D (`acc_vals` slices 0..3, A lowest), 4 = `imm_byte`, 5 = `imm_word`, 6 = none (0), 7 = `loop_val`, 8..11 = full W..Z, 12..15 = bits [19:10] of W..Z. All 10-bit values are zero-extended to 20 bits.
- R3: With `req_mode` = 1 (fractional), offset codes 8..11 contribute bits [19:10] of the register instead of the full value. All other codes behave as in `req_mode` = 0.
- R4: The address is base plus offset modulo 2^20.
- R5: Update code 2 (postbyte bits [8:7]) decrements the base by 1 before the add and writes the decremented value back to the base register.
- R6: Update code 3 adds with the original base and writes base+1 back.
- R7: Update code 1 writes the offset register back incremented. Accumulators wrap within 10 bits. Codes 7..11 add 1. Codes 12..15 add 1024, which steps the upper byte. Offset codes 4, 5 and 6 are never written.
- R8: No base write-back occurs for update codes 0 and 1 or for base code 7. No offset write-back occurs for update codes 0, 2 and 3.
- R9: A direct request accepted at a clock edge raises `res_valid` for exactly the next cycle. The write-back enables are valid only in that cycle.
- R10: With postbyte bit 9 set, `mem_rd_en` rises in the cycle after acceptance with `mem_rd_addr` equal to the computed address, and stays high until `mem_rd_valid`. The cycle after the edge that sees `mem_rd_valid` raises `res_valid` with `res_addr` = `mem_rd_data`, along with the write-backs.
- R11: `req_mode` 2 or 3 gives `res_valid` the next cycle with `res_illegal` = 1, `res_addr` = 0, no write-back and no memory read, even with bit 9 set.
- R12: While `busy` is high, a new request is ignored. The pending read address does not change and no extra result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_postbyte | input | 10 | Addressing postbyte |
| req_mode | input | 2 | 0 plain, 1 fractional, 2/3 unsupported |
| acc_vals | input | 40 | Accumulators A..D, A in bits [9:0] |
| idx_vals | input | 80 | Index registers W..Z, W in bits [19:0] |
| sp_s | input | 20 | First stack pointer |
| sp_u | input | 20 | Second stack pointer |
| pc_val | input | 20 | Program counter |
| loop_val | input | 20 | Loop counter |
| imm_byte | input | 10 | Immediate byte operand |
| imm_word | input | 20 | Immediate word operand |
| busy | output | 1 | Indirect fetch pending |
| mem_rd_en | output | 1 | Pointer read request |
| mem_rd_addr | output | 20 | Pointer read address |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 20 | Pointer value |
| res_valid | output | 1 | Result strobe |
| res_addr | output | 20 | Effective address |
| res_illegal | output | 1 | Unsupported mode was requested |
| wb_base_en | output | 1 | Base register write-back |
| wb_base_sel | output | 3 | Base code being written |
| wb_base_val | output | 20 | New base value |
| wb_off_en | output | 1 | Offset register write-back |
| wb_off_sel | output | 4 | Offset code being written |
| wb_off_val | output | 20 | New offset value |

## Verification
The assertions check the handshake on every cycle. A direct request completes one cycle after acceptance, and an indirect request waits with a stable read address. Unsupported modes stay silent. A base write-back never names "no base", and an offset write-back never names an immediate source or carries accumulator bits above 10. The arithmetic has to come from the bench's scenarios: base and offset selection, fractional narrowing, wrap-around, the direction and timing of each update, and the accumulator and upper-byte step sizes. A reference model checks these scenarios.

// File: rtl/eau_pkg.sv
package eau_pkg;

  typedef struct packed {
    logic       indirect;
    logic [1:0] update;
    logic [3:0] off_code;
    logic [2:0] base_code;
  } postbyte_t;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,
    MODE_FRAC  = 2'd1,
    MODE_EXT   = 2'd2,
    MODE_SEG   = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    UPD_NONE        = 2'd0,
    UPD_INC_OFFSET  = 2'd1,
    UPD_DEC_BASE    = 2'd2,
    UPD_INC_BASE    = 2'd3
  } update_e;

  localparam logic [2:0] BASE_NONE   = 3'd7;
  localparam logic [3:0] OFF_IMM_B   = 4'd4;
  localparam logic [3:0] OFF_IMM_W   = 4'd5;
  localparam logic [3:0] OFF_ZERO    = 4'd6;
  localparam logic [3:0] OFF_LOOP    = 4'd7;

endpackage

// File: rtl/eau_rst_sync.sv
module eau_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_out = stage2_q;

endmodule

// File: rtl/eau_operand_mux.sv
module eau_operand_mux
  import eau_pkg::*;
#(
  parameter int AW = 20,
  parameter int BW = 10
) (
  input  logic [2:0]      base_code,
  input  logic [3:0]      off_code,
  input  logic            frac,
  input  logic [4*BW-1:0] acc_vals,
  input  logic [4*AW-1:0] idx_vals,
  input  logic [AW-1:0]   sp_s,
  input  logic [AW-1:0]   sp_u,
  input  logic [AW-1:0]   pc_val,
  input  logic [AW-1:0]   loop_val,
  input  logic [BW-1:0]   imm_byte,
  input  logic [AW-1:0]   imm_word,
  output logic [AW-1:0]   base_val,
  output logic            base_is_reg,
  output logic [AW-1:0]   off_val,
  output logic [AW-1:0]   off_reg_val,
  output logic [AW-1:0]   off_step,
  output logic            off_is_reg,
  output logic            off_is_acc
);

  localparam int PAD = AW - BW;
  localparam logic [AW-1:0] STEP_LOW  = AW'(1);
  localparam logic [AW-1:0] STEP_HIGH = AW'(1) << PAD;

  logic [AW-1:0] acc_ext [4];
  logic [AW-1:0] idx_full[4];
  logic [AW-1:0] idx_high[4];

  for (genvar i = 0; i < 4; i++) begin : g_unpack
    assign acc_ext[i]  = {{PAD{1'b0}}, acc_vals[i*BW +: BW]};
    assign idx_full[i] = idx_vals[i*AW +: AW];
    assign idx_high[i] = {{PAD{1'b0}}, idx_full[i][AW-1 -: BW]};
  end

  always_comb begin
    base_is_reg = (base_code != BASE_NONE);
    case (base_code)
      3'd0, 3'd1, 3'd2, 3'd3: base_val = idx_full[base_code[1:0]];
      3'd4:                   base_val = sp_s;
      3'd5:                   base_val = sp_u;
      3'd6:                   base_val = pc_val;
      default:                base_val = '0;
    endcase
  end

  always_comb begin
    off_val     = '0;
    off_reg_val = '0;
    off_step    = STEP_LOW;
    off_is_reg  = 1'b0;
    off_is_acc  = 1'b0;
    case (off_code[3:2])
      2'b00: begin
        off_val     = acc_ext[off_code[1:0]];
        off_reg_val = acc_ext[off_code[1:0]];
        off_is_reg  = 1'b1;
        off_is_acc  = 1'b1;
      end
      2'b01: begin
        case (off_code)
          OFF_IMM_B: off_val = {{PAD{1'b0}}, imm_byte};
          OFF_IMM_W: off_val = imm_word;
          OFF_ZERO:  off_val = '0;
          default: begin
            off_val     = loop_val;
            off_reg_val = loop_val;
            off_is_reg  = 1'b1;
          end
        endcase
      end
      2'b10: begin
        off_val     = frac ? idx_high[off_code[1:0]] : idx_full[off_code[1:0]];
        off_reg_val = idx_full[off_code[1:0]];
        off_is_reg  = 1'b1;
      end
      default: begin
        off_val     = idx_high[off_code[1:0]];
        off_reg_val = idx_full[off_code[1:0]];
        off_step    = STEP_HIGH;
        off_is_reg  = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/eau_addr_calc.sv
module eau_addr_calc
  import eau_pkg::*;
#(
  parameter int AW = 20,
  parameter int BW = 10
) (
  input  logic [1:0]    update,
  input  logic [AW-1:0] base_val,
  input  logic          base_is_reg,
  input  logic [AW-1:0] off_val,
  input  logic [AW-1:0] off_reg_val,
  input  logic [AW-1:0] off_step,
  input  logic          off_is_reg,
  input  logic          off_is_acc,
  output logic [AW-1:0] ea,
  output logic          base_wb_en,
  output logic [AW-1:0] base_wb_val,
  output logic          off_wb_en,
  output logic [AW-1:0] off_wb_val
);

  localparam int PAD = AW - BW;
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] base_eff;
  logic [AW-1:0] off_sum;
  logic          dec_base;
  logic          inc_base;

  always_comb begin
    dec_base    = (update == UPD_DEC_BASE);
    inc_base    = (update == UPD_INC_BASE);
    base_eff    = dec_base ? (base_val - ONE) : base_val;
    ea          = base_eff + off_val;
    base_wb_en  = base_is_reg && (dec_base || inc_base);
    base_wb_val = dec_base ? base_eff : (base_val + ONE);
    off_sum     = off_reg_val + off_step;
    off_wb_en   = off_is_reg && (update == UPD_INC_OFFSET);
    off_wb_val  = off_is_acc ? {{PAD{1'b0}}, off_sum[BW-1:0]} : off_sum;
  end

endmodule

// File: rtl/eau_seq.sv
module eau_seq
  import eau_pkg::*;
#(
  parameter int AW = 20,
  parameter int BW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_indirect,
  input  logic          req_illegal,
  input  logic [AW-1:0] ea,
  input  logic [2:0]    base_sel,
  input  logic [3:0]    off_sel,
  input  logic          base_wb_en,
  input  logic [AW-1:0] base_wb_val,
  input  logic          off_wb_en,
  input  logic [AW-1:0] off_wb_val,
  input  logic          mem_rd_valid,
  input  logic [AW-1:0] mem_rd_data,
  output logic          busy,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  output logic          res_valid,
  output logic [AW-1:0] res_addr,
  output logic          res_illegal,
  output logic          wb_base_en,
  output logic [2:0]    wb_base_sel,
  output logic [AW-1:0] wb_base_val,
  output logic          wb_off_en,
  output logic [3:0]    wb_off_sel,
  output logic [AW-1:0] wb_off_val
);

  typedef enum logic {ST_IDLE = 1'b0, ST_FETCH = 1'b1} seq_state_e;

  seq_state_e    state_q, state_n;
  logic          valid_q, valid_n;
  logic          illegal_q, illegal_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [AW-1:0] rd_addr_q;
  logic          bwe_q, owe_q;
  logic [2:0]    bsel_q;
  logic [3:0]    osel_q;
  logic [AW-1:0] bval_q, oval_q;

  logic accept;
  logic finish_fetch;
  logic load_req;
  logic load_result;

  always_comb begin
    accept       = req_valid && (state_q == ST_IDLE);
    finish_fetch = (state_q == ST_FETCH) && mem_rd_valid;
    load_req     = accept;
    load_result  = accept || finish_fetch;

    state_n   = state_q;
    valid_n   = 1'b0;
    illegal_n = illegal_q;
    addr_n    = addr_q;

    if (accept) begin
      illegal_n = req_illegal;
      if (req_illegal) begin
        valid_n = 1'b1;
        addr_n  = '0;
      end else if (req_indirect) begin
        state_n = ST_FETCH;
      end else begin
        valid_n = 1'b1;
        addr_n  = ea;
      end
    end else if (finish_fetch) begin
      state_n = ST_IDLE;
      valid_n = 1'b1;
      addr_n  = mem_rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_n;
      valid_q <= valid_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      illegal_q <= 1'b0;
      addr_q    <= '0;
    end else if (load_result) begin
      illegal_q <= illegal_n;
      addr_q    <= addr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
      bwe_q     <= 1'b0;
      owe_q     <= 1'b0;
      bsel_q    <= '0;
      osel_q    <= '0;
      bval_q    <= '0;
      oval_q    <= '0;
    end else if (load_req) begin
      rd_addr_q <= ea;
      bwe_q     <= base_wb_en && !req_illegal;
      owe_q     <= off_wb_en && !req_illegal;
      bsel_q    <= base_sel;
      osel_q    <= off_sel;
      bval_q    <= base_wb_val;
      oval_q    <= off_wb_val;
    end
  end

  assign busy        = (state_q == ST_FETCH);
  assign mem_rd_en   = (state_q == ST_FETCH);
  assign mem_rd_addr = rd_addr_q;
  assign res_valid   = valid_q;
  assign res_addr    = addr_q;
  assign res_illegal = illegal_q;
  assign wb_base_en  = valid_q && bwe_q;
  assign wb_base_sel = bsel_q;
  assign wb_base_val = bval_q;
  assign wb_off_en   = valid_q && owe_q;
  assign wb_off_sel  = osel_q;
  assign wb_off_val  = oval_q;

  AST_DIRECT_ONE_CYCLE: // R9
    assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && (!req_indirect || req_illegal)) |=> res_valid);

  AST_INDIRECT_WAITS: // R10
    assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_indirect && !req_illegal) |=> (mem_rd_en && !res_valid && mem_rd_addr == $past(ea)));

  AST_FETCH_HOLDS: // R12
    assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && !res_valid && $stable(mem_rd_addr)));

  AST_ILLEGAL_QUIET: // R11
    assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_illegal) |-> (!wb_base_en && !wb_off_en && res_addr == '0 && !mem_rd_en));

  AST_NO_BASE_NONE_WB: // R8
    assert property (@(posedge clk) disable iff (!rst_n)
      wb_base_en |-> (wb_base_sel != BASE_NONE));

  AST_OFF_WB_IS_REG: // R7
    assert property (@(posedge clk) disable iff (!rst_n)
      wb_off_en |-> (wb_off_sel != OFF_IMM_B && wb_off_sel != OFF_IMM_W && wb_off_sel != OFF_ZERO));

  AST_ACC_WB_NARROW: // R7
    assert property (@(posedge clk) disable iff (!rst_n)
      (wb_off_en && wb_off_sel[3:2] == 2'b00) |-> (wb_off_val[AW-1:BW] == '0));

endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import eau_pkg::*;
#(
  parameter int AW = 20,
  parameter int BW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [9:0]      req_postbyte,
  input  logic [1:0]      req_mode,
  input  logic [4*BW-1:0] acc_vals,
  input  logic [4*AW-1:0] idx_vals,
  input  logic [AW-1:0]   sp_s,
  input  logic [AW-1:0]   sp_u,
  input  logic [AW-1:0]   pc_val,
  input  logic [AW-1:0]   loop_val,
  input  logic [BW-1:0]   imm_byte,
  input  logic [AW-1:0]   imm_word,
  output logic            busy,
  output logic            mem_rd_en,
  output logic [AW-1:0]   mem_rd_addr,
  input  logic            mem_rd_valid,
  input  logic [AW-1:0]   mem_rd_data,
  output logic            res_valid,
  output logic [AW-1:0]   res_addr,
  output logic            res_illegal,
  output logic            wb_base_en,
  output logic [2:0]      wb_base_sel,
  output logic [AW-1:0]   wb_base_val,
  output logic            wb_off_en,
  output logic [3:0]      wb_off_sel,
  output logic [AW-1:0]   wb_off_val
);

  postbyte_t     pb;
  logic          rst_sync_n;
  logic          is_frac;
  logic          is_illegal;
  logic [AW-1:0] base_val, off_val, off_reg_val, off_step;
  logic          base_is_reg, off_is_reg, off_is_acc;
  logic [AW-1:0] ea;
  logic          base_wb_en, off_wb_en;
  logic [AW-1:0] base_wb_val, off_wb_val;

  assign pb         = postbyte_t'(req_postbyte);
  assign is_frac    = (req_mode == MODE_FRAC);
  assign is_illegal = (req_mode == MODE_EXT) || (req_mode == MODE_SEG);

  eau_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  eau_operand_mux #(.AW(AW), .BW(BW)) u_mux (
    .base_code   (pb.base_code),
    .off_code    (pb.off_code),
    .frac        (is_frac),
    .acc_vals    (acc_vals),
    .idx_vals    (idx_vals),
    .sp_s        (sp_s),
    .sp_u        (sp_u),
    .pc_val      (pc_val),
    .loop_val    (loop_val),
    .imm_byte    (imm_byte),
    .imm_word    (imm_word),
    .base_val    (base_val),
    .base_is_reg (base_is_reg),
    .off_val     (off_val),
    .off_reg_val (off_reg_val),
    .off_step    (off_step),
    .off_is_reg  (off_is_reg),
    .off_is_acc  (off_is_acc)
  );

  eau_addr_calc #(.AW(AW), .BW(BW)) u_calc (
    .update      (pb.update),
    .base_val    (base_val),
    .base_is_reg (base_is_reg),
    .off_val     (off_val),
    .off_reg_val (off_reg_val),
    .off_step    (off_step),
    .off_is_reg  (off_is_reg),
    .off_is_acc  (off_is_acc),
    .ea          (ea),
    .base_wb_en  (base_wb_en),
    .base_wb_val (base_wb_val),
    .off_wb_en   (off_wb_en),
    .off_wb_val  (off_wb_val)
  );

  eau_seq #(.AW(AW), .BW(BW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .req_valid    (req_valid),
    .req_indirect (pb.indirect),
    .req_illegal  (is_illegal),
    .ea           (ea),
    .base_sel     (pb.base_code),
    .off_sel      (pb.off_code),
    .base_wb_en   (base_wb_en),
    .base_wb_val  (base_wb_val),
    .off_wb_en    (off_wb_en),
    .off_wb_val   (off_wb_val),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .busy         (busy),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_addr  (mem_rd_addr),
    .res_valid    (res_valid),
    .res_addr     (res_addr),
    .res_illegal  (res_illegal),
    .wb_base_en   (wb_base_en),
    .wb_base_sel  (wb_base_sel),
    .wb_base_val  (wb_base_val),
    .wb_off_en    (wb_off_en),
    .wb_off_sel   (wb_off_sel),
    .wb_off_val   (wb_off_val)
  );

endmodule

// File: tb/ea_unit_test.sv
`timescale 1ns/1ps
module ea_unit_test;

  localparam int AW = 20;
  localparam int BW = 10;
  localparam logic [31:0] AMASK = 32'hFFFFF;
  localparam logic [31:0] BMASK = 32'h3FF;

  typedef struct packed {
    logic [19:0] addr;
    logic        bwe;
    logic [19:0] bval;
    logic        owe;
    logic [19:0] oval;
    logic        ill;
    logic        ind;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [9:0] req_postbyte;
  logic [1:0] req_mode;
  logic [9:0]  acc_r[4];
  logic [19:0] idx_r[4];
  logic [19:0] sp_s, sp_u, pc_val, loop_val, imm_word;
  logic [9:0]  imm_byte;
  logic        mem_rd_valid;
  logic [19:0] mem_rd_data;
  logic [4*BW-1:0] acc_vals;
  logic [4*AW-1:0] idx_vals;
  logic busy, mem_rd_en, res_valid, res_illegal, wb_base_en, wb_off_en;
  logic [19:0] mem_rd_addr, res_addr, wb_base_val, wb_off_val;
  logic [2:0] wb_base_sel;
  logic [3:0] wb_off_sel;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 0;

  assign acc_vals = {acc_r[3], acc_r[2], acc_r[1], acc_r[0]};
  assign idx_vals = {idx_r[3], idx_r[2], idx_r[1], idx_r[0]};

  always #2 clk = ~clk;

  ea_unit #(.AW(AW), .BW(BW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_postbyte(req_postbyte),
    .req_mode(req_mode), .acc_vals(acc_vals), .idx_vals(idx_vals), .sp_s(sp_s),
    .sp_u(sp_u), .pc_val(pc_val), .loop_val(loop_val), .imm_byte(imm_byte),
    .imm_word(imm_word), .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .res_valid(res_valid),
    .res_addr(res_addr), .res_illegal(res_illegal), .wb_base_en(wb_base_en),
    .wb_base_sel(wb_base_sel), .wb_base_val(wb_base_val), .wb_off_en(wb_off_en),
    .wb_off_sel(wb_off_sel), .wb_off_val(wb_off_val)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic exp_t model(input logic [9:0] pb, input logic [1:0] md);
    exp_t e;
    logic [31:0] b, o, breg;
    logic [2:0] bc;
    logic [3:0] oc;
    logic [1:0] up;
    e = '0;
    bc = pb[2:0];
    oc = pb[6:3];
    up = pb[8:7];
    e.ind = pb[9];
    if (md >= 2'd2) begin
      e.ill = 1'b1;
      return e;
    end
    case (bc)
      3'd4: b = {12'h0, sp_s};
      3'd5: b = {12'h0, sp_u};
      3'd6: b = {12'h0, pc_val};
      3'd7: b = 0;
      default: b = {12'h0, idx_r[bc[1:0]]};
    endcase
    breg = b;
    if (oc < 4) o = {22'h0, acc_r[oc[1:0]]};
    else if (oc == 4) o = {22'h0, imm_byte};
    else if (oc == 5) o = {12'h0, imm_word};
    else if (oc == 6) o = 0;
    else if (oc == 7) o = {12'h0, loop_val};
    else if (oc < 12) o = (md == 2'd1) ? ({12'h0, idx_r[oc[1:0]]} >> 10) : {12'h0, idx_r[oc[1:0]]};
    else o = {12'h0, idx_r[oc[1:0]]} >> 10;
    if (up == 2'd2) b = (b - 1) & AMASK;
    e.addr = 20'((b + o) & AMASK);
    e.bwe = (bc != 3'd7) && (up >= 2'd2);
    e.bval = (up == 2'd2) ? 20'(b) : 20'((breg + 1) & AMASK);
    e.owe = (up == 2'd1) && !(oc == 4 || oc == 5 || oc == 6);
    if (oc < 4) e.oval = 20'((acc_r[oc[1:0]] + 1) & BMASK);
    else if (oc == 7) e.oval = 20'((loop_val + 1) & AMASK);
    else if (oc >= 8 && oc < 12) e.oval = 20'((idx_r[oc[1:0]] + 1) & AMASK);
    else e.oval = 20'((idx_r[oc[1:0]] + 1024) & AMASK);
    return e;
  endfunction

  task automatic rand_regs();
    for (int i = 0; i < 4; i++) begin
      acc_r[i] = 10'($urandom);
      idx_r[i] = 20'($urandom);
    end
    sp_s = 20'($urandom); sp_u = 20'($urandom); pc_val = 20'($urandom);
    loop_val = 20'($urandom); imm_byte = 10'($urandom); imm_word = 20'($urandom);
  endtask

  task automatic run_one(input logic [9:0] pb, input logic [1:0] md);
    exp_t e;
    logic [19:0] data;
    string at, bt, ot;
    e = model(pb, md);
    at = e.ill ? "R11" : (e.ind ? "R10" : (md == 2'd1 ? "R3" : "R2"));
    bt = (pb[8:7] == 2'd2) ? "R5" : ((pb[8:7] == 2'd3) ? "R6" : "R8");
    ot = (pb[8:7] == 2'd1) ? "R7" : "R8";
    req_postbyte = pb; req_mode = md; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (e.ind && !e.ill) begin
      chk("R10", "mem_rd_en raised", 32'(mem_rd_en), 1);
      chk("R10", "mem_rd_addr", 32'(mem_rd_addr), 32'(e.addr));
      chk("R10", "no early result", 32'(res_valid), 0);
      for (int k = 0; k < int'($urandom % 4); k++) begin
        req_valid = 1'b1; req_postbyte = 10'($urandom); req_mode = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12", "read addr held while busy", 32'(mem_rd_addr), 32'(e.addr));
        chk("R12", "no result while busy", 32'(res_valid), 0);
      end
      data = 20'($urandom);
      mem_rd_valid = 1'b1; mem_rd_data = data;
      @(negedge clk);
      mem_rd_valid = 1'b0;
      e.addr = data;
    end
    chk(at, "res_valid", 32'(res_valid), 1);
    chk(at, "res_illegal", 32'(res_illegal), 32'(e.ill));
    chk(at, "res_addr", 32'(res_addr), 32'(e.addr));
    chk(at, "mem_rd_en idle", 32'(mem_rd_en), 0);
    chk(bt, "wb_base_en", 32'(wb_base_en), 32'(e.bwe));
    if (e.bwe) begin
      chk(bt, "wb_base_sel", 32'(wb_base_sel), 32'(pb[2:0]));
      chk(bt, "wb_base_val", 32'(wb_base_val), 32'(e.bval));
    end
    chk(ot, "wb_off_en", 32'(wb_off_en), 32'(e.owe));
    if (e.owe) begin
      chk(ot, "wb_off_sel", 32'(wb_off_sel), 32'(pb[6:3]));
      chk(ot, "wb_off_val", 32'(wb_off_val), 32'(e.oval));
    end
  endtask

  function automatic logic [9:0] mk(input logic ind, input logic [1:0] up, input logic [3:0] oc, input logic [2:0] bc);
    return {ind, up, oc, bc};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 1'b0; req_postbyte = '0; req_mode = '0;
    mem_rd_valid = 1'b0; mem_rd_data = '0;
    rand_regs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", "reset res_valid", 32'(res_valid), 0);
    chk("R10", "reset mem_rd_en", 32'(mem_rd_en), 0);
    chk("R12", "reset busy", 32'(busy), 0);

    // R1: each base code with no offset
    for (int b = 0; b < 8; b++) run_one(mk(0, 2'd0, 4'd6, 3'(b)), 2'd0);
    // R2: every offset code on base W
    for (int o = 0; o < 16; o++) run_one(mk(0, 2'd0, 4'(o), 3'd0), 2'd0);
    // R3: fractional on full-register and other codes
    for (int o = 0; o < 16; o++) run_one(mk(0, 2'd0, 4'(o), 3'd1), 2'd1);
    // R4: wrap-around
    sp_s = 20'hFFFFF; imm_word = 20'h00003;
    run_one(mk(0, 2'd0, 4'd5, 3'd4), 2'd0);
    chk("R4", "wrapped address", 32'(res_addr), 32'h2);
    // R5: pre-decrement from zero wraps
    sp_u = 20'h0; imm_byte = 10'h010;
    run_one(mk(0, 2'd2, 4'd4, 3'd5), 2'd0);
    chk("R5", "predec base value", 32'(wb_base_val), 32'hFFFFF);
    chk("R5", "predec address", 32'(res_addr), 32'h0000F);
    // R6: post-increment base
    idx_r[2] = 20'h12345; acc_r[1] = 10'h005;
    run_one(mk(0, 2'd3, 4'd1, 3'd2), 2'd0);
    chk("R6", "postinc address", 32'(res_addr), 32'h1234A);
    chk("R6", "postinc base", 32'(wb_base_val), 32'h12346);
    // R7: accumulator wraps within 10 bits, high byte steps by 1024
    acc_r[3] = 10'h3FF;
    run_one(mk(0, 2'd1, 4'd3, 3'd7), 2'd0);
    chk("R7", "acc wrap", 32'(wb_off_val), 32'h0);
    idx_r[3] = 20'hFFC00;
    run_one(mk(0, 2'd1, 4'd15, 3'd7), 2'd0);
    chk("R7", "high byte step", 32'(wb_off_val), 32'h0);
    run_one(mk(0, 2'd1, 4'd4, 3'd0), 2'd0);
    chk("R7", "immediate not written", 32'(wb_off_en), 0);
    // R8: no base write for base none
    run_one(mk(0, 2'd3, 4'd6, 3'd7), 2'd0);
    chk("R8", "base none no wb", 32'(wb_base_en), 0);
    // R9: result lasts one cycle
    @(negedge clk);
    chk("R9", "res_valid drops", 32'(res_valid), 0);
    // R11: illegal modes with indirect bit
    run_one(mk(1, 2'd3, 4'd8, 3'd0), 2'd2);
    run_one(mk(1, 2'd1, 4'd0, 3'd6), 2'd3);
    // R10: indirect fetches
    for (int i = 0; i < 6; i++) begin
      rand_regs();
      run_one({1'b1, 9'($urandom)}, 2'd0);
    end

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] r;
      logic [1:0] md;
      rand_regs();
      r = 3'($urandom);
      md = (r < 4) ? 2'd0 : ((r < 7) ? 2'd1 : 2'(2 + ($urandom % 2)));
      run_one(10'($urandom), md);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule